// File: doc/BRIEF.md
# Dual-Channel 16-bit Compare-Match Timer

This peripheral provides two independent periodic timers behind one small synchronous register port. Each channel has an up-counter advanced by a prescaled copy of the bus clock. When the counter equals the channel's compare constant on a count tick, the counter returns to zero and a match flag is raised. Together with a per-channel enable, the flag drives that channel's interrupt line.

A single start/stop register at byte offset 0 gates every channel through its own bit position. The per-channel banks follow at a stride of six bytes. Software selects one of four divisors per channel, programs the compare constant, and starts the channel. It can then poll or take the interrupt and acknowledge it by writing the flag back as zero. Reads are combinational from the selected address. Writes take effect at the clock edge on which select and write are both high.

Top module: `cmt_dual16`

## Requirements
- R1: After reset the start/stop register, every control/status register and every counter read 0, every compare constant reads 0xFFFF, and both interrupt outputs are low.
- R2: Registers are 16 bits wide at even byte addresses. The start/stop register is at 0. Channel n's bank starts at 2 + 6·n and holds control/status (+0), counter (+2) and compare constant (+4). A written compare constant or counter value reads back unchanged.
- R3: Bit n of the start/stop register runs channel n when 1 and stops it when 0. Only bits 1:0 are stored; the upper bits read as 0.
- R4: Control/status bits 1:0 set the number of clock cycles per count tick: 0 gives 8, 1 gives 32, 2 gives 128 and 3 gives 512. The first tick after starting from reset comes on the divisor-th clock edge after the start write.
- R5: On a tick where the counter equals the compare constant, the counter goes to 0 and control/status bit 7 (match flag) sets. One period is therefore compare constant + 1 ticks.
- R6: Writing control/status with bit 7 at 0 clears the match flag. Writing it with bit 7 at 1 leaves the flag unchanged, whether it was 0 or 1.
- R7: Interrupt output n is high exactly while channel n's match flag and its enable (control/status bit 6) are both 1. Writing 0 to control/status drops the interrupt and reads back 0.
- R8: A stopped channel holds its counter and its prescaler phase, so a restart continues the partial prescale period.
- R9: A write to a counter loads it at that edge, even while the channel runs, and counting resumes from the loaded value.
- R10: If a flag-clearing write and a match fall on the same edge, the flag stays set.
- R11: The channels are independent. Running, matching or interrupting on one channel leaves the other channel's counter, flag and interrupt untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Byte address of the 16-bit register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr while bus_sel is high, else 0 |
| irq | output | 2 | Per-channel interrupt, bit n for channel n |

## Verification
The counting path is driven with all four divisor codes using a compare constant that never matches. This separates the divisor decode from the match logic. A compare constant of 3 under the smallest divisor then produces repeated matches, which show where the period ends and when the flag and interrupt rise. Flag writes land before a match, on the match edge and after it, which separates the write-zero clear, the write-one no-op and the priority of a match over a clear. A stop placed partway through a prescale period and the later restart show whether prescaler phase is kept. A counter load while running, and one channel active beside an idle one, cover loading and isolation.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  // register data width of the bus port
  localparam int CMT_DW = 16;

  // divisor code width and the widest prescale (2^(3+2*3) = 512)
  localparam int CMT_SEL_W   = 2;
  localparam int CMT_DIV_LOG_BASE = 3;
  localparam int CMT_DIV_LOG_STEP = 2;
  localparam int CMT_PRE_W   = CMT_DIV_LOG_BASE + CMT_DIV_LOG_STEP * ((1 << CMT_SEL_W) - 1);

  // control/status field positions
  localparam int CMT_FLAG_BIT = 7;
  localparam int CMT_IE_BIT   = 6;
  localparam int CMT_SEL_LSB  = 0;

  // address map (byte addresses)
  localparam int CMT_START_ADDR  = 0;
  localparam int CMT_BANK_FIRST  = 2;
  localparam int CMT_BANK_STRIDE = 6;
  localparam int CMT_OFS_CTRL    = 0;
  localparam int CMT_OFS_CNT     = 2;
  localparam int CMT_OFS_CMP     = 4;

  typedef enum logic [CMT_SEL_W-1:0] {
    DIV_BY_8   = 2'd0,
    DIV_BY_32  = 2'd1,
    DIV_BY_128 = 2'd2,
    DIV_BY_512 = 2'd3
  } cmt_div_e;

  function automatic int cmt_bank_base(input int ch);
    return CMT_BANK_FIRST + CMT_BANK_STRIDE * ch;
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
#(
  parameter int PRE_W = CMT_PRE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_i,
  input  logic [CMT_SEL_W-1:0] sel_i,
  output logic                 tick_o
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] mask_c;

  // low bits that must all be one for a tick: 3, 5, 7 or 9
  always_comb begin
    mask_c = ~({PRE_W{1'b1}} << (CMT_DIV_LOG_BASE + CMT_DIV_LOG_STEP * int'(sel_i)));
  end

  always_comb begin
    pre_d  = pre_q;
    tick_o = 1'b0;
    if (run_i) begin
      pre_d  = pre_q + 1'b1;
      tick_o = ((pre_q & mask_c) == mask_c);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R8
  stop_hold_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(pre_q));

  // R4
  pre_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> pre_q == PRE_W'($past(pre_q) + 1'b1));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int DW    = CMT_DW,
  parameter int PRE_W = CMT_PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          ctrl_wr_i,
  input  logic          cnt_wr_i,
  input  logic          cmp_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] cmp_o,
  output logic          irq_o
);

  logic                 tick;
  logic                 match_c;
  logic [DW-1:0]        cnt_q, cnt_d;
  logic [DW-1:0]        cmp_q, cmp_d;
  logic                 flag_q, flag_d;
  logic                 ie_q, ie_d;
  logic [CMT_SEL_W-1:0] sel_q, sel_d;

  cmt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_i),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  // next-state: counter and compare constant
  always_comb begin
    match_c = tick && (cnt_q == cmp_q) && !cnt_wr_i;
    cnt_d   = cnt_q;
    if (cnt_wr_i)     cnt_d = wdata_i;
    else if (match_c) cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + 1'b1;
    cmp_d = cmp_wr_i ? wdata_i : cmp_q;
  end

  // next-state: control/status, a match outranks a clearing write
  always_comb begin
    flag_d = flag_q;
    ie_d   = ie_q;
    sel_d  = sel_q;
    if (ctrl_wr_i) begin
      flag_d = flag_q & wdata_i[CMT_FLAG_BIT];
      ie_d   = wdata_i[CMT_IE_BIT];
      sel_d  = wdata_i[CMT_SEL_LSB +: CMT_SEL_W];
    end
    if (match_c) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmp_q  <= '1;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      sel_q  <= DIV_BY_8;
    end else begin
      cnt_q  <= cnt_d;
      cmp_q  <= cmp_d;
      flag_q <= flag_d;
      ie_q   <= ie_d;
      sel_q  <= sel_d;
    end
  end

  always_comb begin
    ctrl_o                                = '0;
    ctrl_o[CMT_FLAG_BIT]                  = flag_q;
    ctrl_o[CMT_IE_BIT]                    = ie_q;
    ctrl_o[CMT_SEL_LSB +: CMT_SEL_W]      = sel_q;
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;
  assign irq_o = flag_q & ie_q;

  // R5 R10
  match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == cmp_q && !cnt_wr_i) |=> flag_q);

  // R5
  match_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == cmp_q && !cnt_wr_i) |=> cnt_q == '0);

  // R8
  stop_hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !cnt_wr_i) |=> $stable(cnt_q));

  // R9
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> cnt_q == $past(wdata_i));

  // R7
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(ctrl_wr_i));

endmodule

// File: rtl/cmt_regif.sv
module cmt_regif
  import cmt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4,
  parameter int DW     = CMT_DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DW-1:0]        bus_wdata_i,
  input  logic [NUM_CH*DW-1:0] ctrl_rd_i,
  input  logic [NUM_CH*DW-1:0] cnt_rd_i,
  input  logic [NUM_CH*DW-1:0] cmp_rd_i,
  output logic [DW-1:0]        bus_rdata_o,
  output logic [NUM_CH-1:0]    run_o,
  output logic [NUM_CH-1:0]    ctrl_wr_o,
  output logic [NUM_CH-1:0]    cnt_wr_o,
  output logic [NUM_CH-1:0]    cmp_wr_o
);

  logic              wr_c;
  logic              start_hit;
  logic [NUM_CH-1:0] run_q, run_d;
  logic [DW-1:0]     rmux_c;

  assign wr_c      = bus_sel_i && bus_wr_i;
  assign start_hit = (bus_addr_i == ADDR_W'(CMT_START_ADDR));

  always_comb begin
    run_d = run_q;
    if (wr_c && start_hit) run_d = bus_wdata_i[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign run_o = run_q;

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
      localparam int BASE = cmt_bank_base(n);
      assign ctrl_wr_o[n] = wr_c && (bus_addr_i == ADDR_W'(BASE + CMT_OFS_CTRL));
      assign cnt_wr_o[n]  = wr_c && (bus_addr_i == ADDR_W'(BASE + CMT_OFS_CNT));
      assign cmp_wr_o[n]  = wr_c && (bus_addr_i == ADDR_W'(BASE + CMT_OFS_CMP));
    end
  endgenerate

  always_comb begin
    rmux_c = '0;
    if (start_hit) rmux_c[NUM_CH-1:0] = run_q;
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr_i == ADDR_W'(cmt_bank_base(n) + CMT_OFS_CTRL)) rmux_c = ctrl_rd_i[n*DW +: DW];
      if (bus_addr_i == ADDR_W'(cmt_bank_base(n) + CMT_OFS_CNT))  rmux_c = cnt_rd_i[n*DW +: DW];
      if (bus_addr_i == ADDR_W'(cmt_bank_base(n) + CMT_OFS_CMP))  rmux_c = cmp_rd_i[n*DW +: DW];
    end
  end

  assign bus_rdata_o = bus_sel_i ? rmux_c : '0;

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && start_hit) |=> run_q == $past(bus_wdata_i[NUM_CH-1:0]));

  // R3
  start_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_c && start_hit) |=> $stable(run_q));

endmodule

// File: rtl/cmt_dual16.sv
module cmt_dual16
  import cmt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CMT_DW-1:0] bus_wdata,
  output logic [CMT_DW-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int DW = CMT_DW;

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [NUM_CH-1:0]    run;
  logic [NUM_CH-1:0]    ctrl_wr, cnt_wr, cmp_wr;
  logic [NUM_CH*DW-1:0] ctrl_rd, cnt_rd, cmp_rd;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cmt_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DW(DW)) u_regif (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .bus_sel_i   (bus_sel),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .ctrl_rd_i   (ctrl_rd),
    .cnt_rd_i    (cnt_rd),
    .cmp_rd_i    (cmp_rd),
    .bus_rdata_o (bus_rdata),
    .run_o       (run),
    .ctrl_wr_o   (ctrl_wr),
    .cnt_wr_o    (cnt_wr),
    .cmp_wr_o    (cmp_wr)
  );

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      cmt_channel #(.DW(DW), .PRE_W(CMT_PRE_W)) u_ch (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .run_i     (run[n]),
        .ctrl_wr_i (ctrl_wr[n]),
        .cnt_wr_i  (cnt_wr[n]),
        .cmp_wr_i  (cmp_wr[n]),
        .wdata_i   (bus_wdata),
        .ctrl_o    (ctrl_rd[n*DW +: DW]),
        .cnt_o     (cnt_rd[n*DW +: DW]),
        .cmp_o     (cmp_rd[n*DW +: DW]),
        .irq_o     (irq[n])
      );
    end
  endgenerate

  // R11: a stopped channel without writes keeps its interrupt level
  idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!run[0] && !ctrl_wr[0]) |=> $stable(irq[0]));

endmodule

// File: tb/sim_cmt_dual16.sv
module sim_cmt_dual16;

  localparam int A_START = 0;
  localparam int WDOG    = 200000;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [1:0]  irq;

  int n_chk;
  int n_bad;
  bit done;

  cmt_dual16 u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [3:0] a_ctrl(input int ch); return 4'(2 + 6*ch); endfunction
  function automatic logic [3:0] a_cnt(input int ch);  return 4'(4 + 6*ch); endfunction
  function automatic logic [3:0] a_cmp(input int ch);  return 4'(6 + 6*ch); endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // drives at a falling edge; the write lands on the following rising edge
  task automatic wr(input logic [3:0] addr, input logic [15:0] data);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] addr, output logic [15:0] data);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
    #1;
    data = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdchk(input string req, input logic [3:0] addr, input logic [15:0] exp);
    logic [15:0] v;
    rd(addr, v);
    check(req, v, exp);
  endtask

  task automatic t_reset_state();
    do_reset();
    rdchk("R1 start", 4'(A_START), 16'h0000);
    for (int c = 0; c < 2; c++) begin
      rdchk("R1 ctrl", a_ctrl(c), 16'h0000);
      rdchk("R1 cnt",  a_cnt(c),  16'h0000);
      rdchk("R1 cmp",  a_cmp(c),  16'hFFFF);
    end
    check("R1 irq", {14'b0, irq}, 16'h0000);
  endtask

  task automatic t_map();
    do_reset();
    wr(a_cmp(1), 16'hA5C3);
    rdchk("R2 cmp1 readback", a_cmp(1), 16'hA5C3);
    rdchk("R2 cmp0 untouched", a_cmp(0), 16'hFFFF);
    wr(a_cnt(1), 16'h1234);
    rdchk("R2 cnt1 readback", a_cnt(1), 16'h1234);
    rdchk("R2 cnt0 untouched", a_cnt(0), 16'h0000);
    wr(4'(A_START), 16'hFFFF);
    rdchk("R3 start upper bits", 4'(A_START), 16'h0003);
    wr(4'(A_START), 16'h0000);
    rdchk("R3 start cleared", 4'(A_START), 16'h0000);
  endtask

  task automatic t_divisors();
    for (int s = 0; s < 4; s++) begin
      int div;
      div = 8 << (2 * s);
      do_reset();
      wr(a_ctrl(0), 16'(s));
      wr(4'(A_START), 16'h0001);
      step(3 * div - 1);
      rdchk("R4 before third tick", a_cnt(0), 16'd2);
      step(1);
      rdchk("R4 on third tick", a_cnt(0), 16'd3);
    end
  endtask

  task automatic t_match_flag();
    do_reset();
    wr(a_cmp(0), 16'd3);
    wr(a_ctrl(0), 16'h0040);
    wr(4'(A_START), 16'h0001);
    step(31);
    rdchk("R5 cnt at constant", a_cnt(0), 16'd3);
    rdchk("R5 no flag yet", a_ctrl(0), 16'h0040);
    check("R7 irq low", {14'b0, irq}, 16'h0000);
    step(1);
    rdchk("R5 cnt wraps", a_cnt(0), 16'd0);
    rdchk("R5 flag set", a_ctrl(0), 16'h00C0);
    check("R7 irq high", {14'b0, irq}, 16'h0001);
    step(31);
    wr(a_ctrl(0), 16'h0040);          // clear on the second match edge
    rdchk("R10 match wins over clear", a_ctrl(0), 16'h00C0);
    wr(a_ctrl(0), 16'h00C0);
    rdchk("R6 write one keeps set flag", a_ctrl(0), 16'h00C0);
    wr(a_ctrl(0), 16'h0040);
    rdchk("R6 write zero clears", a_ctrl(0), 16'h0040);
    check("R7 irq follows clear", {14'b0, irq}, 16'h0000);
    wr(a_ctrl(0), 16'h00C0);
    rdchk("R6 write one does not set", a_ctrl(0), 16'h0040);
    step(28);
    check("R7 irq low before third match", {14'b0, irq}, 16'h0000);
    step(1);
    check("R7 irq on third match", {14'b0, irq}, 16'h0001);
    wr(a_ctrl(0), 16'h0080);
    rdchk("R7 enable off keeps flag", a_ctrl(0), 16'h0080);
    check("R7 irq masked", {14'b0, irq}, 16'h0000);
    wr(a_ctrl(0), 16'h0000);
    rdchk("R7 zero write", a_ctrl(0), 16'h0000);
    check("R7 irq after zero write", {14'b0, irq}, 16'h0000);
  endtask

  task automatic t_stop_hold();
    do_reset();
    wr(4'(A_START), 16'h0001);
    step(4);
    wr(4'(A_START), 16'h0000);        // prescaler phase 5 of 8
    step(100);
    rdchk("R8 counter held", a_cnt(0), 16'd0);
    rdchk("R3 stopped bit", 4'(A_START), 16'h0000);
    wr(4'(A_START), 16'h0001);
    step(2);
    rdchk("R8 no tick yet", a_cnt(0), 16'd0);
    step(1);
    rdchk("R8 phase kept", a_cnt(0), 16'd1);
  endtask

  task automatic t_load();
    do_reset();
    wr(4'(A_START), 16'h0001);
    step(20);
    rdchk("R9 counting", a_cnt(0), 16'd2);
    wr(a_cnt(0), 16'h0100);
    rdchk("R9 load while running", a_cnt(0), 16'h0100);
    step(3);
    rdchk("R9 continues from load", a_cnt(0), 16'h0101);
  endtask

  task automatic t_independent();
    do_reset();
    wr(a_cmp(1), 16'd1);
    wr(a_ctrl(1), 16'h0041);
    wr(4'(A_START), 16'h0002);
    step(63);
    check("R11 no irq yet", {14'b0, irq}, 16'h0000);
    rdchk("R11 ch1 counting", a_cnt(1), 16'd1);
    step(1);
    check("R11 only ch1 irq", {14'b0, irq}, 16'h0002);
    rdchk("R11 ch1 wrapped", a_cnt(1), 16'd0);
    rdchk("R11 ch0 counter idle", a_cnt(0), 16'd0);
    rdchk("R11 ch0 flag idle", a_ctrl(0), 16'h0000);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    t_reset_state();
    t_map();
    t_divisors();
    t_match_flag();
    t_stop_hold();
    t_load();
    t_independent();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule